// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block brings an embedded display panel and its backlight up and down in a fixed order. A power-on request starts the sequence. The block turns on the panel supply, waits for the panel's hot-plug detect (HPD) under a timeout, starts link training, and enables video. Once the source reports that video is valid, it turns on the backlight supply and then the backlight LED enable and PWM gate. A power-off request reverses the order. The power-off request is also accepted part-way through power-up. In that case the block unwinds only the outputs that are already active.

All waits are programmable in milliseconds through 16-bit inputs. A parameterised clock prescaler supplies the one-millisecond tick. HPD is ignored during a guard window that starts at supply enable, because some panels glitch HPD early in power-on. The same power-on reference bounds the wait for HPD. If the HPD wire is not connected, a mode input replaces that wait with the full fixed delay. A missing HPD removes panel power and sets a sticky fault flag. After panel power is removed, a minimum off time must pass before the block powers up again. A power-on request that arrives during that time is held until the off time ends.

Top module: `panel_pwr_seq`

## Requirements
- R1: Outputs enable in the order panel supply, then video enable, then backlight supply, then LED enable and PWM gate together. A later output in this order is never active while an earlier one is inactive. The panel supply rises in the first cycle after a power-on request is accepted.
- R2: HPD is ignored for guard_ms milliseconds after supply enable. If HPD is high throughout power-up, the training strobe appears guard_ms*PRESCALE+2 cycles after the first cycle with supply on.
- R3: The HPD timeout is measured from supply enable, not from the end of the guard window. If HPD never rises and hpd_ms > guard_ms, the panel supply drops hpd_ms*PRESCALE+1 cycles after it rose, and fault goes high in that same cycle.
- R4: When no_hpd is 1, HPD is ignored entirely. Training starts max(hpd_ms*PRESCALE+1, guard_ms*PRESCALE+2) cycles after supply enable, and no fault is raised.
- R5: train_start is high for exactly one cycle. video enable rises in the cycle after train_done is seen.
- R6: The backlight supply stays off while vid_ok is low. It rises one cycle after vid_ok is seen. LED enable and PWM gate follow bl_ms*PRESCALE+1 cycles later.
- R7: On a power-off request from full power, LED enable and PWM gate drop first. The backlight supply, video enable and panel supply then follow in that order, each bl_ms*PRESCALE+1 cycles after the one before.
- R8: The fault flag stays set until the next power-on request, and that request clears it.
- R9: After the panel supply drops, it stays off for at least off_ms*PRESCALE+1 cycles. A power-on request during that time is held and acted on when the time ends.
- R10: A power-off request during the HPD guard or wait keeps only the panel supply on. The supply then drops after bl_ms*PRESCALE+1 cycles.
- R11: A delay of zero performs no wait. Each millisecond is PRESCALE clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | 1 | One-cycle power-on request |
| off_req | input | 1 | One-cycle power-off request |
| no_hpd | input | 1 | 1: HPD not wired, use the fixed delay |
| hpd | input | 1 | Hot-plug detect, already synchronised |
| train_done | input | 1 | Link training finished |
| vid_ok | input | 1 | Source video valid |
| guard_ms | input | 16 | HPD ignore window from supply enable |
| hpd_ms | input | 16 | HPD timeout / fixed delay from supply enable |
| bl_ms | input | 16 | Backlight and power-down step delay |
| off_ms | input | 16 | Minimum panel off time |
| panel_en | output | 1 | Panel supply enable |
| train_start | output | 1 | Link training start strobe |
| vid_en | output | 1 | Video enable |
| bl_pwr | output | 1 | Backlight supply enable |
| led_en | output | 1 | Backlight LED enable |
| pwm_en | output | 1 | Backlight PWM gate |
| fault | output | 1 | Sticky HPD timeout flag |

## Verification
The hardest situation to reach is the interplay between the guard window and the HPD timeout, because both are counted from supply enable. The bench holds HPD high from the very first cycle so that any early acceptance shows up as a training strobe that arrives too soon. It holds HPD low with a timeout longer than the guard window to check where the fault falls. Random delay sets include zeros and cases where the timeout is shorter than the guard window. Power-on requests are sent during the off time, and power-off requests are sent inside the guard window, to check the held request and the abort path.

// File: rtl/pps_pkg.sv
// Shared types for the panel power sequencer.
package pps_pkg;
    typedef enum logic [3:0] {
        ST_OFF, ST_COOL, ST_GUARD, ST_HPDW, ST_TRAIN, ST_VIDEO,
        ST_BLUP, ST_ON, ST_DNLED, ST_DNBL, ST_DNVID
    } pps_state_e;
endpackage

// File: rtl/pps_ms_timer.sv
// Millisecond timer: a prescaler makes a 1 ms tick and a saturating counter
// counts ticks since the last clear. done is high once the count reaches target.
// Assumes clr is pulsed on the edge that enters a timed interval.
module pps_ms_timer #(
    parameter int PRESCALE = 100000,
    parameter int DLY_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [DLY_W-1:0] target,
    output logic             done
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

    logic [PW-1:0]    presc;
    logic [DLY_W-1:0] ms_cnt;

    // Prescaler and elapsed-millisecond count, restarted on clr.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            presc  <= '0;
            ms_cnt <= '0;
        end else if (presc == PLAST) begin
            presc <= '0;
            if (ms_cnt != '1) ms_cnt <= ms_cnt + 1'b1;
        end else begin
            presc <= presc + 1'b1;
        end
    end

    // Interval complete once enough milliseconds have passed.
    assign done = (ms_cnt >= target);
endmodule

// File: rtl/pps_fsm.sv
// Sequencing state machine. It chooses the delay for each timed state, restarts
// the timer on state changes (except guard to HPD wait, which shares the power-on
// reference), holds power-on requests during the off time and keeps the fault flag.
module pps_fsm #(
    parameter int DLY_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_req,
    input  logic              off_req,
    input  logic              no_hpd,
    input  logic              hpd,
    input  logic              train_done,
    input  logic              vid_ok,
    input  logic [DLY_W-1:0]  guard_ms,
    input  logic [DLY_W-1:0]  hpd_ms,
    input  logic [DLY_W-1:0]  bl_ms,
    input  logic [DLY_W-1:0]  off_ms,
    input  logic              tmr_done,
    output logic              tmr_clr,
    output logic [DLY_W-1:0]  tmr_target,
    output pps_pkg::pps_state_e state,
    output logic              train_start,
    output logic              fault
);
    import pps_pkg::*;

    pps_state_e nxt;
    logic       pend;
    logic       timeout;

    // Next-state selection.
    always_comb begin
        nxt     = state;
        timeout = 1'b0;
        unique case (state)
            ST_OFF:   if (on_req) nxt = ST_GUARD;
            ST_COOL:  if (tmr_done) nxt = (pend || on_req) ? ST_GUARD : ST_OFF;
            ST_GUARD: if (off_req) nxt = ST_DNVID;
                      else if (tmr_done) nxt = ST_HPDW;
            ST_HPDW: begin
                if (off_req) nxt = ST_DNVID;
                else if (!no_hpd && hpd) nxt = ST_TRAIN;
                else if (tmr_done) begin
                    nxt     = no_hpd ? ST_TRAIN : ST_COOL;
                    timeout = !no_hpd;
                end
            end
            ST_TRAIN: if (off_req) nxt = ST_DNVID;
                      else if (train_done) nxt = ST_VIDEO;
            ST_VIDEO: if (off_req) nxt = ST_DNVID;
                      else if (vid_ok) nxt = ST_BLUP;
            ST_BLUP:  if (off_req) nxt = ST_DNBL;
                      else if (tmr_done) nxt = ST_ON;
            ST_ON:    if (off_req) nxt = ST_DNLED;
            ST_DNLED: if (tmr_done) nxt = ST_DNBL;
            ST_DNBL:  if (tmr_done) nxt = ST_DNVID;
            ST_DNVID: if (tmr_done) nxt = ST_COOL;
            default:  nxt = ST_OFF;
        endcase
    end

    // Delay selection for the current timed state.
    always_comb begin
        unique case (state)
            ST_GUARD:                    tmr_target = guard_ms;
            ST_HPDW:                     tmr_target = hpd_ms;
            ST_BLUP, ST_DNLED,
            ST_DNBL, ST_DNVID:           tmr_target = bl_ms;
            ST_COOL:                     tmr_target = off_ms;
            default:                     tmr_target = '0;
        endcase
    end

    // Restart the timer on each state change except guard to HPD wait.
    assign tmr_clr = (nxt != state) && !(state == ST_GUARD && nxt == ST_HPDW);

    // State, held request, training strobe and sticky fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            pend        <= 1'b0;
            train_start <= 1'b0;
            fault       <= 1'b0;
        end else begin
            state       <= nxt;
            train_start <= (nxt == ST_TRAIN) && (state != ST_TRAIN);
            if (nxt != ST_COOL || off_req) pend <= 1'b0;
            else if (on_req && state == ST_COOL) pend <= 1'b1;
            if (timeout) fault <= 1'b1;
            else if (on_req) fault <= 1'b0;
        end
    end
endmodule

// File: rtl/pps_out_dec.sv
// Output decode: each enable is a pure function of the sequencer state.
module pps_out_dec (
    input  pps_pkg::pps_state_e state,
    output logic panel_en,
    output logic vid_en,
    output logic bl_pwr,
    output logic led_en,
    output logic pwm_en
);
    import pps_pkg::*;

    // Map each state to the set of outputs that are active in it.
    always_comb begin
        panel_en = !(state inside {ST_OFF, ST_COOL});
        vid_en   = state inside {ST_VIDEO, ST_BLUP, ST_ON, ST_DNLED, ST_DNBL};
        bl_pwr   = state inside {ST_BLUP, ST_ON, ST_DNLED};
        led_en   = (state == ST_ON);
        pwm_en   = (state == ST_ON);
    end
endmodule

// File: rtl/panel_pwr_seq.sv
// Display panel power sequencer top: connects the ms timer, the state machine
// and the output decode. Inputs are assumed synchronous to clk.
module panel_pwr_seq #(
    parameter int PRESCALE = 100000,
    parameter int DLY_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_req,
    input  logic             off_req,
    input  logic             no_hpd,
    input  logic             hpd,
    input  logic             train_done,
    input  logic             vid_ok,
    input  logic [DLY_W-1:0] guard_ms,
    input  logic [DLY_W-1:0] hpd_ms,
    input  logic [DLY_W-1:0] bl_ms,
    input  logic [DLY_W-1:0] off_ms,
    output logic             panel_en,
    output logic             train_start,
    output logic             vid_en,
    output logic             bl_pwr,
    output logic             led_en,
    output logic             pwm_en,
    output logic             fault
);
    pps_pkg::pps_state_e state;
    logic                tmr_clr, tmr_done;
    logic [DLY_W-1:0]    tmr_target;

    pps_ms_timer #(.PRESCALE(PRESCALE), .DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr),
        .target(tmr_target), .done(tmr_done)
    );

    pps_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .no_hpd(no_hpd), .hpd(hpd), .train_done(train_done), .vid_ok(vid_ok),
        .guard_ms(guard_ms), .hpd_ms(hpd_ms), .bl_ms(bl_ms), .off_ms(off_ms),
        .tmr_done(tmr_done), .tmr_clr(tmr_clr), .tmr_target(tmr_target),
        .state(state), .train_start(train_start), .fault(fault)
    );

    pps_out_dec u_dec (
        .state(state), .panel_en(panel_en), .vid_en(vid_en),
        .bl_pwr(bl_pwr), .led_en(led_en), .pwm_en(pwm_en)
    );
endmodule

// File: rtl/panel_pwr_seq_chk.sv
// Property checker for the panel power sequencer, bound to every instance.
module panel_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic panel_en,
    input logic train_start,
    input logic vid_en,
    input logic bl_pwr,
    input logic led_en,
    input logic pwm_en,
    input logic fault
);
    // R1
    vid_needs_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vid_en |-> panel_en);
    // R1
    bl_needs_vid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bl_pwr |-> vid_en);
    // R6
    led_needs_bl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (led_en || pwm_en) |-> bl_pwr);
    // R5
    train_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |=> !train_start);
    // R5
    train_panel_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        train_start |-> (panel_en && !vid_en));
    // R7
    bl_drop_after_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bl_pwr) |-> !led_en);
    // R3
    fault_drops_panel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> !panel_en);
endmodule

bind panel_pwr_seq panel_pwr_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .panel_en(panel_en), .train_start(train_start),
    .vid_en(vid_en), .bl_pwr(bl_pwr), .led_en(led_en), .pwm_en(pwm_en),
    .fault(fault)
);

// File: tb/panel_pwr_seq_test.sv
module panel_pwr_seq_test;
    localparam int P = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic on_req = 0, off_req = 0, no_hpd = 0, hpd = 0, train_done = 0, vid_ok = 0;
    logic [15:0] guard_ms = 0, hpd_ms = 0, bl_ms = 0, off_ms = 0;
    logic panel_en, train_start, vid_en, bl_pwr, led_en, pwm_en, fault;

    int n_chk = 0;
    int n_bad = 0;
    int order_bad = 0;

    always #2 clk = ~clk;

    panel_pwr_seq #(.PRESCALE(P)) uut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .off_req(off_req),
        .no_hpd(no_hpd), .hpd(hpd), .train_done(train_done), .vid_ok(vid_ok),
        .guard_ms(guard_ms), .hpd_ms(hpd_ms), .bl_ms(bl_ms), .off_ms(off_ms),
        .panel_en(panel_en), .train_start(train_start), .vid_en(vid_en),
        .bl_pwr(bl_pwr), .led_en(led_en), .pwm_en(pwm_en), .fault(fault)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sig(input int s);
        case (s)
            0: return int'(panel_en);
            1: return int'(train_start);
            2: return int'(vid_en);
            3: return int'(bl_pwr);
            4: return int'(led_en);
            default: return int'(fault);
        endcase
    endfunction

    function automatic int exp_train(input int g, input int h, input bit nh);
        int a = g * P + 2;
        int b = h * P + 1;
        if (nh && b > a) return b;
        return a;
    endfunction

    // Ordering monitor for R1/R6 invariants.
    always @(negedge clk) begin
        if (rst_n) begin
            if ((vid_en && !panel_en) || (bl_pwr && !vid_en) ||
                (led_en && !bl_pwr) || (led_en != pwm_en)) order_bad++;
        end
    end

    task automatic count_until(input int s, input int v, output int n);
        n = 0;
        while (sig(s) != v && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_on();
        on_req = 1; @(negedge clk); on_req = 0;
    endtask

    task automatic pulse_off();
        off_req = 1; @(negedge clk); off_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Full power-up and power-down, then a held request and an abort.
    task automatic full_cycle(input int g, input int h, input int b, input int o, input bit nh);
        int n;
        guard_ms = 16'(g); hpd_ms = 16'(h); bl_ms = 16'(b); off_ms = 16'(o);
        no_hpd = nh; hpd = 1; vid_ok = 0;
        pulse_on();
        check("R1 panel first", int'(panel_en), 1);
        count_until(1, 1, n);
        if (nh) check("R4 fixed hpd delay", n, exp_train(g, h, nh));
        else    check("R2 hpd guard", n, exp_train(g, h, nh));
        check("R1 video off at train", int'(vid_en), 0);
        train_done = 1; @(negedge clk); train_done = 0;
        check("R5 strobe single", int'(train_start), 0);
        check("R5 video after train", int'(vid_en), 1);
        idle(5);
        check("R6 backlight waits video", int'(bl_pwr), 0);
        vid_ok = 1; @(negedge clk);
        check("R6 bl supply", int'(bl_pwr), 1);
        count_until(4, 1, n);
        check("R6 led delay", n, b * P + 1);
        check("R11 pwm with led", int'(pwm_en), 1);
        pulse_off();
        check("R7 led first off", int'(led_en), 0);
        check("R7 bl still on", int'(bl_pwr), 1);
        count_until(3, 0, n);
        check("R7 bl off step", n, b * P + 1);
        count_until(2, 0, n);
        check("R7 video off step", n, b * P + 1);
        count_until(0, 0, n);
        check("R7 panel off step", n, b * P + 1);
        vid_ok = 0; hpd = 0;
        pulse_on();
        count_until(0, 1, n);
        check("R9 off time with held request", n, o * P);
        pulse_off();
        check("R10 abort video off", int'(vid_en), 0);
        count_until(0, 0, n);
        check("R10 abort panel drop", n, b * P + 1);
        idle(o * P + 3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        idle(3);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset panel", int'(panel_en), 0);
        check("R1 reset outputs", int'(vid_en | bl_pwr | led_en | train_start), 0);
        check("R8 reset fault", int'(fault), 0);

        // Directed: zero delays (R11), and timeout shorter than guard with no HPD wire.
        full_cycle(0, 0, 0, 0, 1'b0);
        full_cycle(0, 0, 0, 0, 1'b1);
        full_cycle(3, 1, 1, 2, 1'b1);
        full_cycle(2, 6, 2, 1, 1'b1);

        // Fault path: HPD never rises, timeout counted from supply enable (R3).
        guard_ms = 2; hpd_ms = 5; bl_ms = 1; off_ms = 1; no_hpd = 0; hpd = 0;
        pulse_on();
        count_until(0, 0, n);
        check("R3 timeout from power-on", n, 5 * P + 1);
        check("R3 fault raised", int'(fault), 1);
        idle(2 * P + 4);
        check("R8 fault sticky", int'(fault), 1);
        check("R9 stays off", int'(panel_en), 0);
        pulse_on();
        check("R8 fault cleared", int'(fault), 0);
        check("R8 powered again", int'(panel_en), 1);
        idle(3);
        check("R2 guard holds training", int'(train_start | vid_en), 0);
        pulse_off();
        count_until(0, 0, n);
        check("R10 abort in guard", n, 1 * P + 1);
        idle(2 * P + 3);

        // Random delay sets.
        for (int i = 0; i < 10; i++) begin
            full_cycle(int'($urandom_range(0, 3)), int'($urandom_range(0, 6)),
                       int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                       1'($urandom_range(0, 1)));
        end

        check("R1 R6 output ordering", order_bad, 0);
        summary();
        $finish;
    end
endmodule